// File: doc/BRIEF.md
# Swizzled Shared-Memory Address Generator

This block turns a logical coordinate inside an operand tile into a physical byte address in a banked on-chip scratch memory. A coordinate is a row number and a byte column. A tile descriptor gives the start address, the byte step between horizontal atoms (lead step), the byte step between groups of eight rows (stride step), a swizzle mode and a row phase. The swizzle permutes 16-byte chunks inside each 8-row atom by XOR with the row index, so that filling the tile along rows and reading it down columns both spread over the 32 four-byte banks. The data in the tile does not change, only where each byte sits.

Coordinates enter on a valid/ready stream. Each accepted coordinate leaves one cycle later as an address together with its bank number. A built-in conflict counter watches every address handed downstream. It groups them 32 at a time, as one warp-wide access, and reports the largest number of distinct addresses that fall in one bank. The descriptor must stay stable while coordinates that use it are in flight.

Top module: `swz_addr_gen`

## Requirements
- R1: The address is start + (row/8)·stride + (col/W)·lead + (row mod 8)·W + 16·phys_chunk + (col mod 16), truncated to ADDR_W bits. The atom width W is 128 bytes for mode codes 0 and 3, 64 for code 2 and 32 for code 1.
- R2: Mode code 0 (no swizzle) leaves the chunk unchanged: phys_chunk = col[6:4]. Reading one column down eight rows then lands every row in the same bank.
- R3: Mode code 3 (128-byte swizzle) sets phys_chunk = col[6:4] XOR p. Here p = (row + phase) mod 8, and phase is the 3-bit descriptor row phase.
- R4: Mode code 2 (64-byte swizzle) XORs chunk bits col[5:4] with the low two bits of p. Mode code 1 (32-byte swizzle) XORs chunk bit col[4] with the low bit of p.
- R5: A nonzero row phase shifts the XOR pattern by adding the phase to the row before the XOR. The phase has no other effect on the address.
- R6: The bank output equals address bits [6:2], which selects one of 32 four-byte banks.
- R7: A coordinate accepted on a clock edge appears on the output after that edge, one cycle of latency. While the output is valid and not taken, in_ready is low and the address and bank hold steady.
- R8: After reset, out_valid and conf_valid are low and in_ready is high.
- R9: After every 32nd address taken downstream, conf_valid pulses high for one cycle. conf_degree then gives the largest count of distinct addresses sharing one bank in that group, from 1 to 32.
- R10: Repeated identical addresses within a group count once toward their bank, so a broadcast read reports a degree of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_start | input | ADDR_W | Tile start byte address |
| desc_lead | input | OFS_W | Byte step between horizontal atoms |
| desc_stride | input | OFS_W | Byte step between 8-row groups |
| desc_mode | input | 2 | Swizzle mode: 0 none, 1 32-byte, 2 64-byte, 3 128-byte |
| desc_phase | input | 3 | Row phase added before the XOR |
| in_valid | input | 1 | Coordinate valid |
| in_ready | output | 1 | Coordinate accepted when high with in_valid |
| in_row | input | ROW_W | Logical row |
| in_col | input | COL_W | Logical byte column |
| out_valid | output | 1 | Address valid |
| out_ready | input | 1 | Downstream takes the address |
| out_addr | output | ADDR_W | Physical byte address |
| out_bank | output | 5 | Bank index of out_addr |
| conf_valid | output | 1 | One-cycle pulse after each group of 32 |
| conf_degree | output | 6 | Worst-case distinct addresses in one bank |

## Verification
The assertions check four things on every cycle. The output holds still and in_ready stays low under backpressure. The bank always matches the address bits. The byte offset inside a chunk passes through unchanged. The conflict report is a single-cycle pulse with a degree between 1 and 32. Only the bench's scenarios can show that the address arithmetic and each mode's XOR pattern are right for chosen coordinates. The same holds for the conflict degrees of concrete access groups: a plain column read that collapses onto one bank, the same read spread by the 128-byte swizzle, partial spreading in 64-byte mode, a 32-way worst case, and a broadcast.

// File: rtl/swz_pkg.sv
// Package: shared types for the swizzled address generator.
// Assumes: mode codes are fixed by the descriptor format (0..3).
package swz_pkg;

    typedef enum logic [1:0] {
        SWZ_NONE = 2'd0,
        SWZ_B32  = 2'd1,
        SWZ_B64  = 2'd2,
        SWZ_B128 = 2'd3
    } swz_mode_e;

    // Log2 of the atom row width in bytes for a mode.
    function automatic logic [2:0] atom_shift(input swz_mode_e m);
        case (m)
            SWZ_B32:  atom_shift = 3'd5;
            SWZ_B64:  atom_shift = 3'd6;
            default:  atom_shift = 3'd7;
        endcase
    endfunction

    // Chunk bits that the row phase may flip for a mode.
    function automatic logic [2:0] xor_mask(input swz_mode_e m);
        case (m)
            SWZ_B32:  xor_mask = 3'b001;
            SWZ_B64:  xor_mask = 3'b011;
            SWZ_B128: xor_mask = 3'b111;
            default:  xor_mask = 3'b000;
        endcase
    endfunction

    // Chunk bits that lie inside one atom row.
    function automatic logic [2:0] chunk_mask(input swz_mode_e m);
        case (m)
            SWZ_B32:  chunk_mask = 3'b001;
            SWZ_B64:  chunk_mask = 3'b011;
            default:  chunk_mask = 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/swz_addr_calc.sv
// Module: swz_addr_calc
// Purpose: combinational mapping of (row, byte column) to a swizzled
// physical byte address and its bank index.
// Assumes: COL_W >= 7 and ROW_W >= 4; 16-byte chunks; 8-row atoms.
module swz_addr_calc
    import swz_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int OFS_W    = 16,
    parameter int ROW_W    = 8,
    parameter int COL_W    = 10,
    parameter int NBANK    = 32,
    parameter int BANK_LSB = 2
) (
    input  logic [ADDR_W-1:0]        start_i,
    input  logic [OFS_W-1:0]         lead_i,
    input  logic [OFS_W-1:0]         stride_i,
    input  swz_mode_e                mode_i,
    input  logic [2:0]               phase_i,
    input  logic [ROW_W-1:0]         row_i,
    input  logic [COL_W-1:0]         col_i,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [$clog2(NBANK)-1:0] bank_o
);
    localparam int BANK_W = $clog2(NBANK);
    localparam int GRP_W  = ROW_W - 3;

    logic [2:0]        sh;
    logic [2:0]        row_in;
    logic [2:0]        phased_row;
    logic [2:0]        log_chunk;
    logic [2:0]        phys_chunk;
    logic [GRP_W-1:0]  row_grp;
    logic [COL_W-1:0]  atom_col;
    logic [ADDR_W-1:0] grp_off;
    logic [ADDR_W-1:0] col_off;
    logic [ADDR_W-1:0] inner_off;

    // Split the coordinate into atom position and chunk, then apply the XOR.
    always_comb begin
        sh         = atom_shift(mode_i);
        row_in     = row_i[2:0];
        row_grp    = row_i[ROW_W-1:3];
        phased_row = row_in + phase_i;
        log_chunk  = col_i[6:4] & chunk_mask(mode_i);
        phys_chunk = log_chunk ^ (phased_row & xor_mask(mode_i));
        atom_col   = col_i >> sh;
    end

    // Sum the three offset terms onto the start address.
    always_comb begin
        grp_off   = ADDR_W'(row_grp) * ADDR_W'(stride_i);
        col_off   = ADDR_W'(atom_col) * ADDR_W'(lead_i);
        inner_off = (ADDR_W'(row_in) << sh)
                  | ADDR_W'({phys_chunk, col_i[3:0]});
        addr_o    = start_i + grp_off + col_off + inner_off;
        bank_o    = addr_o[BANK_LSB +: BANK_W];
    end

endmodule

// File: rtl/swz_out_stage.sv
// Module: swz_out_stage
// Purpose: one register stage with valid/ready flow control.
// Assumes: downstream may stall indefinitely; payload holds while stalled.
module swz_out_stage #(
    parameter int DATA_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic              vld_q;
    logic [DATA_W-1:0] data_q;

    // The stage may load when empty or when its content leaves this cycle.
    always_comb in_ready = !vld_q || out_ready;

    // Register the payload and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            data_q <= '0;
        end else if (in_ready) begin
            vld_q <= in_valid;
            if (in_valid) data_q <= in_data;
        end
    end

    assign out_valid = vld_q;
    assign out_data  = data_q;

    // R7: a stalled output keeps its payload.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7: no new coordinate is taken while the output is stalled.
    assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/swz_conflict_ck.sv
// Module: swz_conflict_ck
// Purpose: collects LANES addresses, one per take, and reports the
// largest number of distinct addresses falling into any single bank.
// Assumes: groups start at reset; one address at most per cycle.
module swz_conflict_ck #(
    parameter int ADDR_W   = 18,
    parameter int LANES    = 32,
    parameter int NBANK    = 32,
    parameter int BANK_LSB = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         take_i,
    input  logic [ADDR_W-1:0]            addr_i,
    output logic                         conf_valid_o,
    output logic [$clog2(LANES+1)-1:0]   conf_degree_o
);
    localparam int IDX_W  = $clog2(LANES);
    localparam int DEG_W  = $clog2(LANES + 1);
    localparam int BANK_W = $clog2(NBANK);

    logic [ADDR_W-1:0] seen_q [LANES];
    logic [DEG_W-1:0]  cnt_q  [NBANK];
    logic [IDX_W-1:0]  idx_q;
    logic [DEG_W-1:0]  max_q;
    logic [BANK_W-1:0] bank_new;
    logic [LANES-1:0]  hit;
    logic              dup;
    logic [DEG_W-1:0]  cnt_next;
    logic [DEG_W-1:0]  max_next;

    // Compare the new address with every address already in the group.
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign hit[g] = (IDX_W'(g) < idx_q) && (seen_q[g] == addr_i);
    end

    // Work out the bank count and running maximum after this address.
    always_comb begin
        bank_new = addr_i[BANK_LSB +: BANK_W];
        dup      = |hit;
        cnt_next = cnt_q[bank_new] + (dup ? DEG_W'(0) : DEG_W'(1));
        max_next = (cnt_next > max_q) ? cnt_next : max_q;
    end

    // Record the address, update counts, and close the group on the last lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q         <= '0;
            max_q         <= '0;
            conf_valid_o  <= 1'b0;
            conf_degree_o <= '0;
            for (int b = 0; b < NBANK; b++) cnt_q[b] <= '0;
            for (int l = 0; l < LANES; l++) seen_q[l] <= '0;
        end else begin
            conf_valid_o <= 1'b0;
            if (take_i) begin
                seen_q[idx_q] <= addr_i;
                if (idx_q == IDX_W'(LANES - 1)) begin
                    conf_valid_o  <= 1'b1;
                    conf_degree_o <= max_next;
                    idx_q         <= '0;
                    max_q         <= '0;
                    for (int b = 0; b < NBANK; b++) cnt_q[b] <= '0;
                end else begin
                    idx_q           <= idx_q + 1'b1;
                    max_q           <= max_next;
                    cnt_q[bank_new] <= cnt_next;
                end
            end
        end
    end

    // R9: the report is a single-cycle pulse.
    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conf_valid_o |=> !conf_valid_o);

    // R9, R10: a reported degree lies between 1 and the group size.
    assert_degree_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conf_valid_o |-> (conf_degree_o >= DEG_W'(1) && conf_degree_o <= DEG_W'(LANES)));

endmodule

// File: rtl/swz_addr_gen.sv
// Module: swz_addr_gen (top)
// Purpose: streams tile coordinates through the swizzle address map,
// registers the result, and feeds a bank-conflict counter.
// Assumes: descriptor inputs stay stable while coordinates are in flight.
module swz_addr_gen
    import swz_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int OFS_W    = 16,
    parameter int ROW_W    = 8,
    parameter int COL_W    = 10,
    parameter int LANES    = 32,
    parameter int NBANK    = 32,
    parameter int BANK_LSB = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          desc_start,
    input  logic [OFS_W-1:0]           desc_lead,
    input  logic [OFS_W-1:0]           desc_stride,
    input  logic [1:0]                 desc_mode,
    input  logic [2:0]                 desc_phase,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [ROW_W-1:0]           in_row,
    input  logic [COL_W-1:0]           in_col,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [ADDR_W-1:0]          out_addr,
    output logic [$clog2(NBANK)-1:0]   out_bank,
    output logic                       conf_valid,
    output logic [$clog2(LANES+1)-1:0] conf_degree
);
    localparam int BANK_W = $clog2(NBANK);
    localparam int PAY_W  = ADDR_W + BANK_W;

    logic [ADDR_W-1:0] calc_addr;
    logic [BANK_W-1:0] calc_bank;
    logic [PAY_W-1:0]  stage_out;

    swz_addr_calc #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .NBANK(NBANK), .BANK_LSB(BANK_LSB)
    ) u_calc (
        .start_i (desc_start),
        .lead_i  (desc_lead),
        .stride_i(desc_stride),
        .mode_i  (swz_mode_e'(desc_mode)),
        .phase_i (desc_phase),
        .row_i   (in_row),
        .col_i   (in_col),
        .addr_o  (calc_addr),
        .bank_o  (calc_bank)
    );

    swz_out_stage #(.DATA_W(PAY_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  ({calc_bank, calc_addr}),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (stage_out)
    );

    // Split the registered payload into address and bank.
    always_comb begin
        out_addr = stage_out[ADDR_W-1:0];
        out_bank = stage_out[PAY_W-1:ADDR_W];
    end

    swz_conflict_ck #(
        .ADDR_W(ADDR_W), .LANES(LANES), .NBANK(NBANK), .BANK_LSB(BANK_LSB)
    ) u_conflict (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_i       (out_valid && out_ready),
        .addr_i       (out_addr),
        .conf_valid_o (conf_valid),
        .conf_degree_o(conf_degree)
    );

    // R6: the registered bank agrees with the registered address.
    assert_bank_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bank == out_addr[BANK_LSB +: BANK_W]));

    // R1: with 16-byte aligned descriptor terms the byte within a chunk is kept.
    assert_byte_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && desc_start[3:0] == 4'd0 && desc_lead[3:0] == 4'd0
         && desc_stride[3:0] == 4'd0) |-> (calc_addr[3:0] == in_col[3:0]));

endmodule

// File: tb/swz_addr_gen_tb.sv
module swz_addr_gen_tb;
    localparam int ADDR_W = 18;
    localparam int OFS_W  = 16;
    localparam int ROW_W  = 8;
    localparam int COL_W  = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] desc_start;
    logic [OFS_W-1:0]  desc_lead, desc_stride;
    logic [1:0]        desc_mode;
    logic [2:0]        desc_phase;
    logic              in_valid, in_ready;
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;
    logic              out_valid, out_ready;
    logic [ADDR_W-1:0] out_addr;
    logic [4:0]        out_bank;
    logic              conf_valid;
    logic [5:0]        conf_degree;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    swz_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .desc_start(desc_start), .desc_lead(desc_lead), .desc_stride(desc_stride),
        .desc_mode(desc_mode), .desc_phase(desc_phase),
        .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row), .in_col(in_col),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_bank(out_bank), .conf_valid(conf_valid), .conf_degree(conf_degree)
    );

    typedef struct packed {
        logic [1:0]        mode;
        logic [2:0]        phase;
        logic [ADDR_W-1:0] start;
        logic [OFS_W-1:0]  lead;
        logic [OFS_W-1:0]  stride;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [ADDR_W-1:0] addr;
        logic [4:0]        bank;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 3'd0, 18'h100, 16'h400, 16'h800, 8'd3,  10'h025, 18'h2A5, 5'd9 },  // R2
        '{2'd3, 3'd0, 18'h100, 16'h400, 16'h800, 8'd3,  10'h025, 18'h295, 5'd5 },  // R3
        '{2'd3, 3'd0, 18'h100, 16'h400, 16'h800, 8'd13, 10'h093, 18'hFC3, 5'd16},  // R1 R3
        '{2'd2, 3'd0, 18'h100, 16'h400, 16'h800, 8'd6,  10'h05A, 18'h6BA, 5'd14},  // R4
        '{2'd1, 3'd0, 18'h100, 16'h400, 16'h800, 8'd7,  10'h04F, 18'h9FF, 5'd31},  // R4
        '{2'd3, 3'd5, 18'h100, 16'h400, 16'h800, 8'd2,  10'h010, 18'h260, 5'd24},  // R5
        '{2'd3, 3'd0, 18'h000, 16'h000, 16'h400, 8'd8,  10'h000, 18'h400, 5'd0 }   // R1
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_desc(input logic [1:0] m, input logic [2:0] ph,
                            input logic [ADDR_W-1:0] s, input logic [OFS_W-1:0] ld,
                            input logic [OFS_W-1:0] st);
        desc_mode = m; desc_phase = ph; desc_start = s; desc_lead = ld; desc_stride = st;
    endtask

    // Stream 32 coordinates back to back; pat 0: row i%8, pat 1: row i, pat 2: fixed.
    task automatic run_group(input int pat, input string req, input int exp_deg);
        bit seen;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_row = (pat == 0) ? ROW_W'(i % 8) : (pat == 1) ? ROW_W'(i) : ROW_W'(5);
            in_col = (pat == 2) ? COL_W'(32) : COL_W'(0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        seen = 1'b0;
        for (int w = 0; w < 6 && !seen; w++) begin
            if (conf_valid) seen = 1'b1;
            else @(negedge clk);
        end
        chk(seen, req, 32'(conf_valid), 32'd1);
        chk(conf_degree == 6'(exp_deg), req, 32'(conf_degree), 32'(exp_deg));
        @(negedge clk);
        chk(!conf_valid, "R9 pulse width", 32'(conf_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        in_row = '0; in_col = '0;
        set_desc(2'd0, 3'd0, '0, '0, '0);
        do_reset();

        // R8: state after reset.
        @(negedge clk);
        chk(!out_valid, "R8 out_valid", 32'(out_valid), 32'd0);
        chk(!conf_valid, "R8 conf_valid", 32'(conf_valid), 32'd0);
        chk(in_ready, "R8 in_ready", 32'(in_ready), 32'd1);

        // R1..R6: vector table, one coordinate per vector, latency one cycle (R7).
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            set_desc(VECS[v].mode, VECS[v].phase, VECS[v].start, VECS[v].lead, VECS[v].stride);
            in_row = VECS[v].row; in_col = VECS[v].col; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk(out_valid, "R7 latency", 32'(out_valid), 32'd1);
            chk(out_addr == VECS[v].addr, "R1-table addr", 32'(out_addr), 32'(VECS[v].addr));
            chk(out_bank == VECS[v].bank, "R6 bank", 32'(out_bank), 32'(VECS[v].bank));
        end

        // R7: backpressure holds output and blocks input.
        do_reset();
        @(negedge clk);
        out_ready = 1'b0;
        set_desc(2'd0, 3'd0, 18'h100, 16'h400, 16'h800);
        in_row = 8'd3; in_col = 10'h025; in_valid = 1'b1;
        @(negedge clk);
        chk(!in_ready, "R7 stall ready", 32'(in_ready), 32'd0);
        set_desc(2'd3, 3'd0, 18'h100, 16'h400, 16'h800);
        repeat (2) @(negedge clk);
        chk(out_valid && out_addr == 18'h2A5, "R7 hold", 32'(out_addr), 32'h2A5);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_addr == 18'h295, "R7 next after release", 32'(out_addr), 32'h295);

        // R9 R2: plain column read down 8 rows, 4 times, all in bank 0.
        do_reset();
        set_desc(2'd0, 3'd0, 18'h0, 16'h0, 16'h400);
        run_group(0, "R2 R9 none-mode column", 8);

        // R3 R9: same access with 128-byte swizzle spreads over 8 banks.
        do_reset();
        set_desc(2'd3, 3'd0, 18'h0, 16'h0, 16'h400);
        run_group(0, "R3 R9 swizzled column", 1);

        // R4: 64-byte swizzle spreads only over 4 banks, two rows each.
        do_reset();
        set_desc(2'd2, 3'd0, 18'h0, 16'h0, 16'h400);
        run_group(0, "R4 R9 64B column", 2);

        // R9: 32 distinct rows in one bank, worst case.
        do_reset();
        set_desc(2'd0, 3'd0, 18'h0, 16'h0, 16'h400);
        run_group(1, "R9 worst case", 32);

        // R10: broadcast of one address counts once.
        do_reset();
        set_desc(2'd3, 3'd0, 18'h0, 16'h0, 16'h400);
        run_group(2, "R10 broadcast", 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule